// File: doc/BRIEF.md
# Event and Cycle Performance Counter Unit

This block counts activity inside a processor core. It holds three 32-bit counters. One counter counts clock cycles. Two counters count events. Each event counter watches one line of a 256-bit event-pulse vector, and an 8-bit selector field picks which line. The selector value is the bit index into the vector.

Software controls the unit through a small register bus with four word addresses. One combined control/status word holds the following:
- the global count enable
- one-shot counter clears
- a prescale mode for the cycle counter
- the per-counter interrupt enables
- sticky overflow flags, cleared by writing a one
- both event selectors

Each of the three counters can also be read and loaded directly. When a counter wraps with its interrupt enabled, a level interrupt is raised. The interrupt stays high until software clears the flag.

Top module: `perfmon_unit`

## Requirements
- R1: After reset, all four registers read 0 and `irq_o` is 0.
- R2: The control word layout is as follows. Bit 0 is the enable. Bit 3 is prescale mode. Bits 6:4 are the interrupt enables for event counter 0, event counter 1 and the cycle counter. Bits 10:8 are the overflow flags, in the same order. Bits 19:12 are selector 0. Bits 27:20 are selector 1. Bits 7, 11 and 31:28 always read 0. Writing all ones from a clean state reads back 0x0FFFF079.
- R3: Writing bit 1 as 1 clears both event counters at that write's clock edge. Writing bit 2 as 1 clears the cycle counter and its prescaler. Both bits always read 0.
- R4: While the enable bit is 0, no counter advances, and counter values and flags are held.
- R5: While enabled, event counter k advances by one on every clock edge where `evt_i[selk]` is 1.
- R6: An event counter whose selector is 0xFF never advances. A selector outside the valid codes 0x00–0x0D and 0x10–0x16 also never advances the counter.
- R7: While enabled, the cycle counter advances on every clock. In prescale mode it advances once per 64 enabled clocks, and the first step comes on the 64th clock after a cycle-counter clear.
- R8: Address 0 is the control word, address 1 the cycle counter, address 2 event counter 0 and address 3 event counter 1. Each counter reads back the value last loaded through the bus, as long as it has not advanced since.
- R9: A counter that advances from 0xFFFFFFFF to 0 sets its overflow flag. The flag stays set until it is cleared.
- R10: Writing the control word with a 1 at a flag position clears that flag, unless the same counter wraps in the same cycle.
- R11: `irq_o` is 1 exactly when some overflow flag is set together with its matching interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe for the addressed register |
| bus_addr_i | input | 2 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the addressed register (combinational) |
| evt_i | input | 256 | Single-cycle event pulses, indexed by event code |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench goes after the following corner cases:
- **Event and selector corners.** An event pulse aimed at the unused code 0xFF must not count. A pulse on a gap code such as 0x0E must not count either. A design that only decodes 0xFF would count the gap code.
- **Wrap and flag.** The bench wraps a counter loaded with all ones. The flag must appear while the interrupt stays low until its enable is set. The bench then clears the flag by writing a one to it. A design with the enable wired to the wrong counter, or with ordinary write semantics on the flags, shows a wrong interrupt level or a flag that refuses to clear.
- **Clock counts.** The bench counts enabled clocks exactly: a one-off in how the enable register is sampled gives a cycle count of 9 or 11 instead of 10. In prescale mode, 130 clocks must yield 2.
- **Reserved bits.** An all-ones control write must leave the reserved bits and the clear bits at 0.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  localparam int DATA_W    = 32;
  localparam int SEL_W     = 8;
  localparam int NUM_EVT   = 1 << SEL_W;
  localparam int NUM_CTR   = 3;
  localparam int ADDR_W    = 2;

  localparam logic [SEL_W-1:0] SEL_UNUSED = '1;

  // control word bit positions
  localparam int B_EN      = 0;
  localparam int B_CLR_EVT = 1;
  localparam int B_CLR_CYC = 2;
  localparam int B_DIV     = 3;
  localparam int B_IE_LO   = 4;
  localparam int B_OVF_LO  = 8;
  localparam int B_SEL_LO  = 12;

  // counter slot order shared by flags and interrupt enables
  localparam int SLOT_EV0 = 0;
  localparam int SLOT_EV1 = 1;
  localparam int SLOT_CYC = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL = 2'd0,
    ADR_CYC  = 2'd1,
    ADR_EV0  = 2'd2,
    ADR_EV1  = 2'd3
  } pmu_addr_e;

  typedef struct packed {
    logic [1:0][SEL_W-1:0] sel;
    logic [NUM_CTR-1:0]    ie;
    logic                  div;
    logic                  en;
  } pmu_cfg_t;

  function automatic logic code_valid(input logic [SEL_W-1:0] c);
    return (c <= 8'h0D) || ((c >= 8'h10) && (c <= 8'h16));
  endfunction

endpackage

// File: rtl/pmu_ctrl_reg.sv
module pmu_ctrl_reg
  import pmu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [NUM_CTR-1:0]   wrap_i,
  output pmu_cfg_t             cfg_o,
  output logic [NUM_CTR-1:0]   ovf_o,
  output logic                 clr_evt_o,
  output logic                 clr_cyc_o,
  output logic [DATA_W-1:0]    rd_o,
  output logic                 irq_o
);

  pmu_cfg_t           cfg_q, cfg_d;
  logic [NUM_CTR-1:0] ovf_q, ovf_d, w1c;
  logic               ovf_ce;
  logic               unused_bits;

  assign unused_bits = ^{wdata_i[31:28], wdata_i[11], wdata_i[7]};

  assign w1c = wr_i ? wdata_i[B_OVF_LO +: NUM_CTR] : '0;

  always_comb begin
    cfg_d     = cfg_q;
    cfg_d.en  = wdata_i[B_EN];
    cfg_d.div = wdata_i[B_DIV];
    cfg_d.ie  = wdata_i[B_IE_LO +: NUM_CTR];
    cfg_d.sel = wdata_i[B_SEL_LO +: 2*SEL_W];
  end

  // wrap wins over a simultaneous clear so no overflow is lost
  assign ovf_d  = (ovf_q & ~w1c) | wrap_i;
  assign ovf_ce = wr_i | (|wrap_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (wr_i) cfg_q <= cfg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovf_q <= '0;
    else if (ovf_ce) ovf_q <= ovf_d;
  end

  assign clr_evt_o = wr_i & wdata_i[B_CLR_EVT];
  assign clr_cyc_o = wr_i & wdata_i[B_CLR_CYC];
  assign cfg_o     = cfg_q;
  assign ovf_o     = ovf_q;
  assign irq_o     = |(ovf_q & cfg_q.ie);

  always_comb begin
    rd_o                              = '0;
    rd_o[B_EN]                        = cfg_q.en;
    rd_o[B_DIV]                       = cfg_q.div;
    rd_o[B_IE_LO +: NUM_CTR]          = cfg_q.ie;
    rd_o[B_OVF_LO +: NUM_CTR]         = ovf_q;
    rd_o[B_SEL_LO +: 2*SEL_W]         = cfg_q.sel;
  end

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_i) |=> ((ovf_q & $past(wrap_i)) == $past(wrap_i))); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q))); // R9

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|ovf_q)); // R11

endmodule

// File: rtl/pmu_event_ctr.sv
module pmu_event_ctr
  import pmu_pkg::*;
#(
  parameter int CNT_W = 32
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               clr_i,
  input  logic               load_i,
  input  logic [CNT_W-1:0]   load_val_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               wrap_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hit, ce;

  assign hit = en_i & code_valid(sel_i) & evt_i[sel_i];
  assign ce  = clr_i | load_i | hit;

  always_comb begin
    if (clr_i)       cnt_d = '0;
    else if (load_i) cnt_d = load_val_i;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (ce) cnt_q <= cnt_d;
  end

  assign wrap_o = hit & ~clr_i & ~load_i & (&cnt_q);
  assign cnt_o  = cnt_q;

  AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0)); // R3

  AST_EVT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i && !load_i) |=> $stable(cnt_q)); // R4

  AST_EVT_UNUSED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_i == SEL_UNUSED) && !clr_i && !load_i) |=> $stable(cnt_q)); // R6

endmodule

// File: rtl/pmu_cycle_ctr.sv
module pmu_cycle_ctr #(
  parameter int CNT_W    = 32,
  parameter int PRE_LOG2 = 6
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             div_i,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [PRE_LOG2-1:0] pre_q, pre_d;
  logic                tick, cnt_ce, pre_ce;

  assign tick   = en_i & (~div_i | (&pre_q));
  assign pre_ce = clr_i | (en_i & div_i);
  assign pre_d  = clr_i ? '0 : pre_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_ce) pre_q <= pre_d;
  end

  assign cnt_ce = clr_i | load_i | tick;

  always_comb begin
    if (clr_i)       cnt_d = '0;
    else if (load_i) cnt_d = load_val_i;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign wrap_o = tick & ~clr_i & ~load_i & (&cnt_q);
  assign cnt_o  = cnt_q;

  AST_PRESCALE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && div_i && (pre_q != '1) && !clr_i && !load_i) |=> $stable(cnt_q)); // R7

  AST_CYC_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i && !load_i) |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
  import pmu_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int PRE_LOG2 = 6
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr_i,
  input  logic [1:0]         bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  input  logic [255:0]       evt_i,
  output logic               irq_o
);

  localparam int NUM_EV_CTR = 2;

  pmu_cfg_t                          cfg;
  logic [NUM_CTR-1:0]                ovf, wrap;
  logic                              clr_evt, clr_cyc, wr_ctrl, wr_cyc;
  logic [DATA_W-1:0]                 ctrl_rd;
  logic [CNT_W-1:0]                  cyc_cnt;
  logic [NUM_EV_CTR-1:0][CNT_W-1:0]  ev_cnt;
  logic [NUM_EV_CTR-1:0]             wr_ev;

  assign wr_ctrl = bus_wr_i & (bus_addr_i == ADR_CTRL);
  assign wr_cyc  = bus_wr_i & (bus_addr_i == ADR_CYC);
  assign wr_ev[0] = bus_wr_i & (bus_addr_i == ADR_EV0);
  assign wr_ev[1] = bus_wr_i & (bus_addr_i == ADR_EV1);

  pmu_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (wr_ctrl),
    .wdata_i   (bus_wdata_i),
    .wrap_i    (wrap),
    .cfg_o     (cfg),
    .ovf_o     (ovf),
    .clr_evt_o (clr_evt),
    .clr_cyc_o (clr_cyc),
    .rd_o      (ctrl_rd),
    .irq_o     (irq_o)
  );

  pmu_cycle_ctr #(.CNT_W(CNT_W), .PRE_LOG2(PRE_LOG2)) u_cyc (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (cfg.en),
    .div_i      (cfg.div),
    .clr_i      (clr_cyc),
    .load_i     (wr_cyc),
    .load_val_i (bus_wdata_i[CNT_W-1:0]),
    .cnt_o      (cyc_cnt),
    .wrap_o     (wrap[SLOT_CYC])
  );

  for (genvar g = 0; g < NUM_EV_CTR; g++) begin : g_ev
    pmu_event_ctr #(.CNT_W(CNT_W)) u_ev (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (cfg.en),
      .sel_i      (cfg.sel[g]),
      .evt_i      (evt_i),
      .clr_i      (clr_evt),
      .load_i     (wr_ev[g]),
      .load_val_i (bus_wdata_i[CNT_W-1:0]),
      .cnt_o      (ev_cnt[g]),
      .wrap_o     (wrap[SLOT_EV0 + g])
    );
  end

  always_comb begin
    unique case (bus_addr_i)
      ADR_CTRL: bus_rdata_o = ctrl_rd;
      ADR_CYC:  bus_rdata_o = 32'(cyc_cnt);
      ADR_EV0:  bus_rdata_o = 32'(ev_cnt[0]);
      default:  bus_rdata_o = 32'(ev_cnt[1]);
    endcase
  end

  AST_CTRL_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_i == ADR_CTRL) |-> ((bus_rdata_o & 32'hF0000886) == '0)); // R2

endmodule

// File: tb/perfmon_unit_tb.sv
module perfmon_unit_tb;

  localparam time CLK_PERIOD = 10ns;
  localparam logic [1:0] A_CTRL = 2'd0, A_CYC = 2'd1, A_EV0 = 2'd2, A_EV1 = 2'd3;

  typedef struct packed {
    logic       en;
    logic [7:0] s0;
    logic [7:0] s1;
    logic [7:0] code;
    logic [3:0] n;
    logic [7:0] e0;
    logic [7:0] e1;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h07, 8'h05, 8'h07, 4'd3, 8'd3, 8'd0},
    '{1'b1, 8'h07, 8'h05, 8'h05, 4'd2, 8'd0, 8'd2},
    '{1'b1, 8'h0A, 8'h0A, 8'h0A, 4'd4, 8'd4, 8'd4},
    '{1'b1, 8'hFF, 8'h0B, 8'hFF, 4'd3, 8'd0, 8'd0},
    '{1'b1, 8'h0E, 8'h16, 8'h0E, 4'd2, 8'd0, 8'd0},
    '{1'b1, 8'h16, 8'h0E, 8'h16, 4'd5, 8'd5, 8'd0},
    '{1'b1, 8'h10, 8'h0D, 8'h0D, 4'd1, 8'd0, 8'd1},
    '{1'b0, 8'h07, 8'h07, 8'h07, 4'd3, 8'd0, 8'd0}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_wr;
  logic [1:0]   bus_addr;
  logic [31:0]  bus_wdata;
  logic [31:0]  bus_rdata;
  logic [255:0] evt;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perfmon_unit u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_i    (bus_wr),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .evt_i       (evt),
    .irq_o       (irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [7:0] code, input int n);
    for (int i = 0; i < n; i++) begin
      evt[code] = 1'b1;
      @(posedge clk);
      @(negedge clk);
      evt = '0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, v); check("R1 ctrl", v, 32'h0);
    rd(A_CYC, v);  check("R1 cyc", v, 32'h0);
    rd(A_EV0, v);  check("R1 ev0", v, 32'h0);
    rd(A_EV1, v);  check("R1 ev1", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R5 R6 R4 table walk
    for (int i = 0; i < NV; i++) begin
      wr(A_CTRL, {4'h0, VECS[i].s1, VECS[i].s0, 8'h00, 4'b0110} | {31'b0, VECS[i].en});
      pulse(VECS[i].code, int'(VECS[i].n));
      rd(A_EV0, v); check($sformatf("R5/R6/R4 vec%0d ev0", i), v, {24'b0, VECS[i].e0});
      rd(A_EV1, v); check($sformatf("R5/R6/R4 vec%0d ev1", i), v, {24'b0, VECS[i].e1});
    end

    // R2 R3 reserved and clear bits read zero
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); check("R2 R3 ctrl readback", v, 32'h0FFF_F079);
    wr(A_CTRL, 32'h0);

    // R8 load and readback
    wr(A_EV1, 32'h1234_5678);
    rd(A_EV1, v); check("R8 ev1 load", v, 32'h1234_5678);
    wr(A_CYC, 32'hA5A5_A5A5);
    rd(A_CYC, v); check("R8 cyc load", v, 32'hA5A5_A5A5);

    // R7 R3 normal cycle count: 10 enabled edges
    wr(A_CTRL, 32'h0000_0005);
    repeat (9) @(negedge clk);
    wr(A_CTRL, 32'h0);
    rd(A_CYC, v); check("R7 cyc count", v, 32'd10);
    repeat (5) @(negedge clk);
    rd(A_CYC, v); check("R4 cyc hold", v, 32'd10);

    // R7 prescale: 130 enabled edges -> 2
    wr(A_CTRL, 32'h0000_000D);
    repeat (129) @(negedge clk);
    wr(A_CTRL, 32'h0);
    rd(A_CYC, v); check("R7 prescale count", v, 32'd2);

    // R9 R11 R10 event counter 0 wrap
    wr(A_EV0, 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h0FF0_7001);
    pulse(8'h07, 1);
    rd(A_EV0, v);  check("R9 ev0 wrapped", v, 32'h0);
    rd(A_CTRL, v); check("R9 ev0 flag", v, 32'h0FF0_7101);
    check("R11 irq masked", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'h0FF0_7011);
    check("R11 irq raised", {31'b0, irq}, 32'h1);
    rd(A_CTRL, v); check("R9 flag sticky", v, 32'h0FF0_7111);
    wr(A_CTRL, 32'h0FF0_7111);
    rd(A_CTRL, v); check("R10 flag cleared", v, 32'h0FF0_7011);
    check("R11 irq dropped", {31'b0, irq}, 32'h0);

    // R9 R11 cycle counter wrap
    wr(A_CTRL, 32'h0);
    wr(A_CYC, 32'hFFFF_FFFE);
    wr(A_CTRL, 32'h0FFF_F041);
    repeat (2) @(negedge clk);
    check("R11 cyc irq", {31'b0, irq}, 32'h1);
    wr(A_CTRL, 32'h0FFF_F040);
    rd(A_CYC, v);  check("R9 cyc after wrap", v, 32'd1);
    rd(A_CTRL, v); check("R9 cyc flag", v, 32'h0FFF_F440);
    wr(A_CTRL, 32'h0000_0400);
    rd(A_CTRL, v); check("R10 cyc flag cleared", v, 32'h0);
    check("R11 irq low", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule